// File: doc/BRIEF.md
# Indirect address region translator

This block takes a latched 32-bit bus address and turns it into the board's internal routing information. It reports an invalid-address flag, one active-low space flag for each target device, and a 16-bit internal word address that carries address bits 17:2. A top-level decode on bits 23:20 sorts every address into one of 16 regions. Inside the register region a second decode picks the target device. The local interface space is checked for its legal sub-blocks.

Four decision-buffer regions do not own storage of their own. An access to one of them is rewritten into the register window of the device that holds the data. Address bits 7:4 pick that device. The translated address gets a permuted copy of the buffer number, a window offset in bits 9:8, and a forced bit 3 for the bunch-counter word. The bus master never sees the rewrite.

The decode is started by a one-cycle enable, `dec_en`. One clock later the registered result appears, together with a one-cycle `res_vld` pulse. The result then holds until the next enable. There is no back-pressure: a new enable may come on any cycle, including back to back, and each enable produces exactly one result.

Top module: `vme_region_xlat`

## Requirements
- R1: While reset is asserted and until the first enable after it: `res_vld` is 0, `addr_bad` is 0, every space flag is 1 (inactive), and `iaddr` is 0.
- R2: The result for the address present with `dec_en`=1 appears on the outputs one clock later, with `res_vld`=1 for that cycle. While `dec_en` is 0, every output except `res_vld` keeps its value, whatever `addr` does.
- R3: Region field `addr[23:20]`. Values 1, 4 and 7 are valid; value 4 drives `ram_sel_n` low. Values 2, 3, 5, 6 and C to F set `addr_bad`=1.
- R4: In region 0, `addr[19:16]` selects the target. 0 drives `glob_sel_n` low, 1 drives `trk_sel_n` low, and 2 to 9 drive `pipe_sel_n[n-2]` low. Code F is valid and drives no flag. Codes A to E set `addr_bad`.
- R5: In region 0 with target code F, the address is invalid if `addr[15:8]` is nonzero or if `addr[7:6]`=10. Values 00, 01 and 11 of `addr[7:6]` are valid.
- R6: For every non-indirect access, `iaddr` equals `addr[17:2]`.
- R7: Region values 8 to B are indirect. If `addr[19:8]` is nonzero, the address is invalid. Otherwise `addr[7:4]` routes the access: 0 or 1 drive `trk_sel_n` low, 2 to 9 drive `pipe_sel_n[n-2]` low, and A to F set `addr_bad`.
- R8: For a valid indirect access, the translated byte address is built as follows. Bit 7 takes `addr[22]`, bit 6 takes `addr[23]`, bit 5 takes `addr[21]` and bit 4 takes `addr[20]`. Bits 9:8 are 00 for the track device and 10 for a pipe device. All other bits pass through. `iaddr` carries translated bits 17:2.
- R9: For a valid indirect access with `addr[7:4]`=0, translated bit 3 (`iaddr[1]`) is 1.
- R10: At most one space flag is low at a time, and none is low while `addr_bad` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dec_en | input | 1 | Decode the current address this cycle |
| addr | input | 32 | Latched bus address |
| res_vld | output | 1 | One-cycle pulse: a new result is on the outputs |
| addr_bad | output | 1 | The decoded address is invalid |
| ram_sel_n | output | 1 | RAM space selected (active low) |
| glob_sel_n | output | 1 | Global device space selected (active low) |
| trk_sel_n | output | 1 | Track device space selected (active low) |
| pipe_sel_n | output | 8 | Pipe device n space selected (active low) |
| iaddr | output | 16 | Internal word address (translated bits 17:2) |

## Verification
Every decode result is due exactly one clock after the cycle in which `dec_en` was high, so it can be read at the falling edge that follows that rising edge. The driver queues each expected result as it applies the enable. The monitor pops one entry at every falling edge where `res_vld` is high, so back-to-back enables stay matched one for one. The hold rule is checked separately: the address is changed while the enable is low, and the bench confirms the registered outputs stay put a few cycles later.

// File: rtl/vrx_pkg.sv
package vrx_pkg;
  localparam int NPIPE    = 8;
  localparam int IA_LSB   = 2;
  localparam int IA_MSB   = 17;
  localparam int IAW      = IA_MSB - IA_LSB + 1;
  localparam int PIPE_C0  = 2;
  localparam logic [3:0] RG_REG  = 4'h0;
  localparam logic [3:0] RG_PROM = 4'h1;
  localparam logic [3:0] RG_RAM  = 4'h4;
  localparam logic [3:0] RG_CFG  = 4'h7;
  localparam logic [3:0] TG_GLOB = 4'h0;
  localparam logic [3:0] TG_TRK  = 4'h1;
  localparam logic [3:0] TG_LOC  = 4'hF;
  localparam logic [1:0] LOC_HOLE = 2'b10;

  typedef struct packed {
    logic             bad;
    logic             ram;
    logic             glob;
    logic             trk;
    logic [NPIPE-1:0] pipe;
    logic [IAW-1:0]   ia;
  } xlat_t;
endpackage

// File: rtl/vrx_region_dec.sv
module vrx_region_dec
  import vrx_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic [AW-1:0]    addr,
  output logic             bad_dir,
  output logic             ram,
  output logic             glob,
  output logic             trk,
  output logic [NPIPE-1:0] pipe,
  output logic             dbuf,
  output logic             ind_win
);
  logic [3:0] rgn;
  logic [3:0] tgt;
  logic       in_reg;
  logic       loc_ok;
  logic       valid_dir;

  assign rgn    = addr[23:20];
  assign tgt    = addr[19:16];
  assign in_reg = (rgn == RG_REG);
  assign loc_ok = in_reg && (tgt == TG_LOC) && (addr[15:8] == 8'h00)
                  && (addr[7:6] != LOC_HOLE);

  assign glob = in_reg && (tgt == TG_GLOB);
  assign trk  = in_reg && (tgt == TG_TRK);
  assign ram  = (rgn == RG_RAM);

  for (genvar i = 0; i < NPIPE; i++) begin : g_pipe
    assign pipe[i] = in_reg && (tgt == 4'(i + PIPE_C0));
  end

  // regions 8..B: decision buffers
  assign dbuf    = (rgn[3:2] == 2'b10);
  assign ind_win = dbuf && (addr[19:8] == 12'h000);

  assign valid_dir = (rgn == RG_PROM) || ram || (rgn == RG_CFG)
                     || glob || trk || (|pipe) || loc_ok;
  assign bad_dir   = !dbuf && !valid_dir;
endmodule

// File: rtl/vrx_ind_xlat.sv
module vrx_ind_xlat
  import vrx_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic [AW-1:0]    addr,
  input  logic             dbuf,
  input  logic             ind_win,
  output logic             trk_i,
  output logic [NPIPE-1:0] pipe_i,
  output logic             ind_bad,
  output logic [IAW-1:0]   xaddr
);
  logic [3:0]      code;
  logic            hit;
  logic [IA_MSB:0] b;

  assign code  = addr[7:4];
  assign trk_i = ind_win && (code < 4'(PIPE_C0));

  for (genvar i = 0; i < NPIPE; i++) begin : g_pipe
    assign pipe_i[i] = ind_win && (code == 4'(i + PIPE_C0));
  end

  assign hit     = trk_i || (|pipe_i);
  assign ind_bad = dbuf && !hit;

  always_comb begin
    b = addr[IA_MSB:0];
    if (hit) begin
      b[9:8] = (|pipe_i) ? 2'b10 : 2'b00;
      b[7:4] = {addr[22], addr[23], addr[21], addr[20]};
      b[3]   = addr[3] | (code == 4'h0);
    end
  end

  assign xaddr = b[IA_MSB:IA_LSB];
endmodule

// File: rtl/vrx_out_reg.sv
module vrx_out_reg
  import vrx_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  en,
  input  xlat_t d,
  output xlat_t q,
  output logic  vld
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q   <= '0;
      vld <= 1'b0;
    end else begin
      vld <= en;
      if (en) q <= d;
    end
  end
endmodule

// File: rtl/vme_region_xlat.sv
module vme_region_xlat
  import vrx_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dec_en,
  input  logic [AW-1:0]    addr,
  output logic             res_vld,
  output logic             addr_bad,
  output logic             ram_sel_n,
  output logic             glob_sel_n,
  output logic             trk_sel_n,
  output logic [NPIPE-1:0] pipe_sel_n,
  output logic [IAW-1:0]   iaddr
);
  logic             bad_dir, ram, glob, trk_d, dbuf, ind_win;
  logic [NPIPE-1:0] pipe_d, pipe_i;
  logic             trk_i, ind_bad;
  logic [IAW-1:0]   xaddr;
  xlat_t            nxt, cur;

  vrx_region_dec #(.AW(AW)) u_dec (
    .addr(addr), .bad_dir(bad_dir), .ram(ram), .glob(glob), .trk(trk_d),
    .pipe(pipe_d), .dbuf(dbuf), .ind_win(ind_win)
  );

  vrx_ind_xlat #(.AW(AW)) u_ind (
    .addr(addr), .dbuf(dbuf), .ind_win(ind_win), .trk_i(trk_i),
    .pipe_i(pipe_i), .ind_bad(ind_bad), .xaddr(xaddr)
  );

  always_comb begin
    nxt.bad  = bad_dir | ind_bad;
    nxt.ram  = ram;
    nxt.glob = glob;
    nxt.trk  = trk_d | trk_i;
    nxt.pipe = pipe_d | pipe_i;
    nxt.ia   = xaddr;
  end

  vrx_out_reg u_reg (
    .clk(clk), .rst_n(rst_n), .en(dec_en), .d(nxt), .q(cur), .vld(res_vld)
  );

  assign addr_bad   = cur.bad;
  assign ram_sel_n  = ~cur.ram;
  assign glob_sel_n = ~cur.glob;
  assign trk_sel_n  = ~cur.trk;
  assign pipe_sel_n = ~cur.pipe;
  assign iaddr      = cur.ia;
endmodule

// File: rtl/vrx_chk.sv
module vrx_chk
  import vrx_pkg::*;
#(
  parameter int AW = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             dec_en,
  input logic [AW-1:0]    addr,
  input logic             res_vld,
  input logic             addr_bad,
  input logic             ram_sel_n,
  input logic             glob_sel_n,
  input logic             trk_sel_n,
  input logic [NPIPE-1:0] pipe_sel_n,
  input logic [IAW-1:0]   iaddr
);
  logic [NPIPE+2:0] act;
  assign act = ~{ram_sel_n, glob_sel_n, trk_sel_n, pipe_sel_n};

  p_vld_after_en_r2: assert property (@(posedge clk) disable iff (!rst_n)
    dec_en |=> res_vld);

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_en |=> ($stable(iaddr) && $stable(addr_bad) && $stable(act)));

  p_one_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(act));

  p_bad_no_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
    addr_bad |-> (act == '0));

  p_swap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (res_vld && !addr_bad && $past(addr[23:22]) == 2'b10)
    |-> (iaddr[5:2] == {$past(addr[22]), $past(addr[23]),
                        $past(addr[21]), $past(addr[20])}));

  p_bunch_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (res_vld && !addr_bad && $past(addr[23:22]) == 2'b10
     && $past(addr[7:4]) == 4'h0) |-> iaddr[1]);

  p_direct_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (res_vld && $past(addr[23:22]) != 2'b10) |-> (iaddr == $past(addr[17:2])));
endmodule

bind vme_region_xlat vrx_chk #(.AW(AW)) u_chk (.*);

// File: tb/vme_region_xlat_test.sv
module vme_region_xlat_test;
  localparam int W = 28;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        dec_en = 1'b0;
  logic [31:0] addr = '0;
  logic        res_vld, addr_bad, ram_sel_n, glob_sel_n, trk_sel_n;
  logic [7:0]  pipe_sel_n;
  logic [15:0] iaddr;

  int checks = 0;
  int failures = 0;
  logic [W-1:0] exp_q[$];
  string        tag_q[$];

  always #5 clk = ~clk;

  vme_region_xlat uut (
    .clk(clk), .rst_n(rst_n), .dec_en(dec_en), .addr(addr), .res_vld(res_vld),
    .addr_bad(addr_bad), .ram_sel_n(ram_sel_n), .glob_sel_n(glob_sel_n),
    .trk_sel_n(trk_sel_n), .pipe_sel_n(pipe_sel_n), .iaddr(iaddr)
  );

  function automatic logic [W-1:0] got();
    return {addr_bad, ram_sel_n, glob_sel_n, trk_sel_n, pipe_sel_n, iaddr};
  endfunction

  // expected {bad, ram_n, glob_n, trk_n, pipe_n[7:0], iaddr}
  function automatic logic [W-1:0] model(logic [31:0] a);
    logic        bad = 1'b0;
    logic [10:0] fl = '1;   // {ram, glob, trk, pipe7..0}, active low
    logic [17:0] b = a[17:0];
    logic [3:0]  r = a[23:20];
    logic [3:0]  t = a[19:16];
    logic [3:0]  c = a[7:4];
    if (r == 4'h0) begin
      if (t == 4'h0) fl[9] = 1'b0;
      else if (t == 4'h1) fl[8] = 1'b0;
      else if (t >= 4'h2 && t <= 4'h9) fl[t-2] = 1'b0;
      else if (t == 4'hF) bad = (a[15:8] != 0) || (a[7:6] == 2'b10);
      else bad = 1'b1;
    end else if (r == 4'h1 || r == 4'h7) begin
      bad = 1'b0;
    end else if (r == 4'h4) begin
      fl[10] = 1'b0;
    end else if (r >= 4'h8 && r <= 4'hB) begin
      if (a[19:8] != 0 || c > 4'h9) bad = 1'b1;
      else begin
        if (c <= 4'h1) begin fl[8] = 1'b0; b[9:8] = 2'b00; end
        else begin fl[c-2] = 1'b0; b[9:8] = 2'b10; end
        b[7] = a[22]; b[6] = a[23]; b[5] = a[21]; b[4] = a[20];
        if (c == 4'h0) b[3] = 1'b1;
      end
    end else bad = 1'b1;
    return {bad, fl, b[17:2]};
  endfunction

  task automatic check(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // driver: one enable per call, enables may be back to back
  task automatic apply(logic [31:0] a, string tag);
    @(negedge clk);
    addr = a;
    dec_en = 1'b1;
    exp_q.push_back(model(a));
    tag_q.push_back(tag);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      dec_en = 1'b0;
    end
  endtask

  // monitor: result due at the falling edge after the enabling rising edge
  always @(negedge clk) begin
    if (rst_n && res_vld) begin
      if (exp_q.size() == 0) begin
        checks++; failures++;
        $display("FAIL R2 actual=unexpected result expected=none");
      end else begin
        check(tag_q.pop_front(), got(), exp_q.pop_front());
      end
    end
  end

  initial begin
    #2000000;
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [W-1:0] held;
    repeat (3) @(negedge clk);
    check("R1", {res_vld, got()}, {1'b0, 1'b0, 11'h7FF, 16'h0000});
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", {res_vld, got()}, {1'b0, 1'b0, 11'h7FF, 16'h0000});

    apply(32'h2840_1234, "R3");
    apply(32'h2810_0000, "R3");
    apply(32'h2870_00FC, "R3");
    apply(32'h2820_0000, "R3");
    apply(32'h28C0_0000, "R3");
    apply(32'h2850_0000, "R3");
    apply(32'h2800_0000, "R4");
    apply(32'h2801_0104, "R4 R6");
    apply(32'h2802_0ABC, "R4 R6");
    apply(32'h2809_FFFC, "R4 R6");
    apply(32'h280A_0000, "R4");
    apply(32'h280E_0000, "R4");
    apply(32'h280F_0040, "R5");
    apply(32'h280F_00C4, "R5");
    apply(32'h280F_0000, "R5");
    apply(32'h280F_0080, "R5");
    apply(32'h280F_0100, "R5");
    idle(2);
    apply(32'h2880_0020, "R7 R8");
    apply(32'h2890_0024, "R7 R8");
    apply(32'h28B0_0098, "R7 R8");
    apply(32'h28A0_0010, "R7 R8");
    apply(32'h2880_0000, "R9");
    apply(32'h28B0_0004, "R9");
    apply(32'h2880_00A0, "R7");
    apply(32'h2880_00F0, "R7");
    apply(32'h2880_0100, "R7");
    apply(32'h2890_1020, "R7");
    apply(32'h2890_0014, "R10");
    idle(2);

    held = got();
    addr = 32'h2802_0000;
    idle(3);
    check("R2", got(), held);
    check("R2", {28'(exp_q.size()), res_vld}, {28'd0, 1'b0});

    apply(32'hFFFF_FFFF, "R3");
    apply(32'h0000_0000, "R4");
    idle(2);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule